// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block sits on a two-wire serial control bus as a slave and gives the bus master access to a small bank of eight byte-wide registers. Those registers hold control and status for a power stage. The clock and data lines are sampled with the system clock, and start and stop conditions are recovered from them. The block answers to a 7-bit address. Its upper five bits are fixed and its lower two come from a static strap input. The block drives the data line only by pulling it low, through an output-enable.

The first data byte of a write transfer loads an 8-bit index. Its low seven bits pick a register, and its top bit turns on post-increment after every completed data byte. Further bytes of the same write land in the selected registers. A repeated start followed by a read address returns bytes from the current index. The register bank mixes four kinds of bit: sticky event flags that the host clears by writing zero, live read-only flags, ordinary read/write fields, and reserved bits that always read zero.

Top module: `twowire_regslave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal binary 10000 followed by `addr_sel_i[1:0]`. Bit 0 of that byte is the direction, where 1 means read. On a mismatch the slave leaves the line released for the acknowledge and for every later bit, and it changes no register until the next start.
- R2: A fall of data while the clock is high is a start, and a rise of data while the clock is high is a stop. A start at any point, repeated or not, restarts address reception. A stop returns the slave to idle with the line released.
- R3: After every byte the slave receives (address or data) and accepts, it pulls the data line low during the ninth clock pulse. It releases the line after the falling clock edge that ends that pulse.
- R4: In a read, each byte goes out MSB first and changes only while the clock is low. The slave releases the line for the master's acknowledge bit. If the master leaves that bit high, the slave sends nothing more and keeps the line released.
- R5: The index resets to 0, so a read issued before any index write returns register 0 (status). The first data byte after a write address is loaded into the index and is not stored in any register.
- R6: If bit 7 of the index is 1, the low seven bits of the index step up by one after each completed data byte, read or write. If bit 7 is 0, the index stays fixed.
- R7: After reset the control and configuration registers read 0x00 and both volume registers read 0xFF.
- R8: Register map by index: 0 status, 1 fault, 2 initial state, 3 volume reading, 4 control, 5 configuration, 6 channel-1 volume, 7 channel-2 volume. In control only bits 7, 6 and 2..0 are writable. In configuration bits 6..0 are writable. The volume registers are fully writable. Every other bit and every index from 8 upward reads 0 and ignores writes.
- R9: Status bit 7 is set by `ovl_evt_i` and status bit 6 by `ocl_evt_i`. Each stays set until the host writes 0 to it. Writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the bit set.
- R10: Status bits 2..0 reflect `stat_live_i`. Fault bits 3..0 reflect `fault_live_i`. Initial-state bits 5..4 reflect `spk_miss_i`. The volume-reading register reflects `vol_adc_i`. Writes to all of these have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the data line is pulled low |
| addr_sel_i | input | 2 | Static low two bits of the slave address |
| ovl_evt_i | input | 1 | Overload event, sets status bit 7 |
| ocl_evt_i | input | 1 | Current-limit event, sets status bit 6 |
| stat_live_i | input | 3 | Live silence-mute, muted, fault flags (status 2..0) |
| fault_live_i | input | 4 | Live fault flags (fault 3..0) |
| spk_miss_i | input | 2 | Speaker-missing flags, channel 2 then 1 (initial state 5..4) |
| vol_adc_i | input | 8 | Digitised volume setting |
| ctrl_o | output | 8 | Control register contents |
| cfg_o | output | 8 | Configuration register contents |
| vol1_o | output | 8 | Channel-1 volume register |
| vol2_o | output | 8 | Channel-2 volume register |

## Verification
Several properties are checked on every cycle by assertions:
- a start always re-enters address reception, and a stop always leaves the slave idle and released;
- the driven line never changes while the synchronised clock is high, and the idle state never drives;
- a sticky status bit rises after every event and falls only after a host write;
- any change of the index is either a load or a single step.

Address matching against the strap, the MSB-first byte order, the master-NACK ending, the write masks and the set-over-clear outcome depend on whole bus transfers. Only the bench's scenarios can show these, by reading the registers back over the bus.

// File: rtl/twr_pkg.sv
package twr_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACKGEN,
        S_TX,
        S_ACKCHK
    } bus_st_e;

    localparam logic [6:0] IDX_STATUS = 7'd0;
    localparam logic [6:0] IDX_FAULT  = 7'd1;
    localparam logic [6:0] IDX_INIT   = 7'd2;
    localparam logic [6:0] IDX_VADC   = 7'd3;
    localparam logic [6:0] IDX_CTRL   = 7'd4;
    localparam logic [6:0] IDX_CFG    = 7'd5;
    localparam logic [6:0] IDX_VOL1   = 7'd6;
    localparam logic [6:0] IDX_VOL2   = 7'd7;
endpackage

// File: rtl/twr_linesync.sv
module twr_linesync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_o,
    output logic stop_o
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev_d, prev_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] sh_d, sh_q;
        always_comb sh_d = {sh_q[STAGES-2:0], raw[g]};
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end
        assign synced[g] = sh_q[STAGES-1];
    end

    always_comb prev_d = synced;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign scl_o    = synced[1];
    assign sda_o    = synced[0];
    assign scl_rise = synced[1] & ~prev_q[1];
    assign scl_fall = ~synced[1] & prev_q[1];
    assign start_o  = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
    assign stop_o   = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];
endmodule

// File: rtl/twr_engine.sv
module twr_engine
    import twr_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_h,
    input  logic       sda_h,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start,
    input  logic       stop,
    input  logic [1:0] addr_sel,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       idx_wr,
    output logic       reg_wr,
    output logic       adv,
    output logic [7:0] wr_data
);
    typedef struct packed {
        bus_st_e    st;
        logic [2:0] cnt;
        logic [7:0] sh;
        logic       rw;
        logic       is_addr;
        logic       first;
        logic       full;
        logic       mack;
        logic       oe;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        idx_wr = 1'b0;
        reg_wr = 1'b0;
        adv    = 1'b0;
        if (stop) begin
            d.st = S_IDLE;
            d.oe = 1'b0;
        end else if (start) begin
            d.st      = S_RX;
            d.is_addr = 1'b1;
            d.cnt     = '0;
            d.full    = 1'b0;
            d.oe      = 1'b0;
        end else begin
            case (q.st)
                S_RX: begin
                    if (scl_rise && !q.full) begin
                        d.sh  = {q.sh[6:0], sda_h};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        if (q.is_addr) begin
                            if (q.sh[7:1] == {ADDR_HI, addr_sel}) begin
                                d.oe      = 1'b1;
                                d.rw      = q.sh[0];
                                d.is_addr = 1'b0;
                                d.first   = ~q.sh[0];
                                d.st      = S_ACKGEN;
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else begin
                            d.oe    = 1'b1;
                            d.st    = S_ACKGEN;
                            d.first = 1'b0;
                            if (q.first) begin
                                idx_wr = 1'b1;
                            end else begin
                                reg_wr = 1'b1;
                                adv    = 1'b1;
                            end
                        end
                    end
                end
                S_ACKGEN: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.sh = rd_data;
                            d.oe = ~rd_data[7];
                            adv  = 1'b1;
                            d.st = S_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = S_RX;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.oe = 1'b0;
                            d.st = S_ACKCHK;
                        end else begin
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                            d.cnt = q.cnt + 3'd1;
                        end
                    end
                end
                S_ACKCHK: begin
                    if (scl_rise) begin
                        d.mack = sda_h;
                    end else if (scl_fall) begin
                        if (!q.mack) begin
                            d.sh  = rd_data;
                            d.oe  = ~rd_data[7];
                            d.cnt = '0;
                            adv   = 1'b1;
                            d.st  = S_TX;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.mack    <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.oe;
    assign wr_data = q.sh;

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.st == S_RX && q.is_addr && !q.oe)); // R2
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (q.st == S_IDLE && !q.oe)); // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_IDLE) |-> !sda_oe); // R1
    AST_OE_LOW_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_h); // R4
endmodule

// File: rtl/twr_regs.sv
module twr_regs
    import twr_pkg::*;
#(
    parameter logic [7:0] CTRL_MASK = 8'hC7,
    parameter logic [7:0] CFG_MASK  = 8'h7F,
    parameter logic [7:0] VOL_RST   = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       reg_wr,
    input  logic       adv,
    input  logic [7:0] wr_data,
    input  logic       ovl_evt,
    input  logic       ocl_evt,
    input  logic [2:0] stat_live,
    input  logic [3:0] fault_live,
    input  logic [1:0] spk_miss,
    input  logic [7:0] vol_adc,
    output logic [7:0] rd_data,
    output logic [7:0] ctrl,
    output logic [7:0] cfg,
    output logic [7:0] vol1,
    output logic [7:0] vol2
);
    typedef struct packed {
        logic [7:0] idx;
        logic       ovl;
        logic       ocl;
        logic [7:0] ctrl;
        logic [7:0] cfg;
        logic [7:0] vol1;
        logic [7:0] vol2;
    } regs_t;

    regs_t d, q;
    logic [6:0] sel;

    assign sel = q.idx[6:0];

    always_comb begin
        d = q;
        if (reg_wr) begin
            case (sel)
                IDX_STATUS: begin
                    if (!wr_data[7]) d.ovl = 1'b0;
                    if (!wr_data[6]) d.ocl = 1'b0;
                end
                IDX_CTRL: d.ctrl = wr_data & CTRL_MASK;
                IDX_CFG:  d.cfg  = wr_data & CFG_MASK;
                IDX_VOL1: d.vol1 = wr_data;
                IDX_VOL2: d.vol2 = wr_data;
                default: ;
            endcase
        end
        if (ovl_evt) d.ovl = 1'b1;
        if (ocl_evt) d.ocl = 1'b1;
        if (idx_wr)
            d.idx = wr_data;
        else if (adv && q.idx[7])
            d.idx = {1'b1, q.idx[6:0] + 7'd1};
    end

    always_comb begin
        case (sel)
            IDX_STATUS: rd_data = {q.ovl, q.ocl, 3'b000, stat_live};
            IDX_FAULT:  rd_data = {4'b0000, fault_live};
            IDX_INIT:   rd_data = {2'b00, spk_miss, 4'b0000};
            IDX_VADC:   rd_data = vol_adc;
            IDX_CTRL:   rd_data = q.ctrl;
            IDX_CFG:    rd_data = q.cfg;
            IDX_VOL1:   rd_data = q.vol1;
            IDX_VOL2:   rd_data = q.vol2;
            default:    rd_data = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.vol1 <= VOL_RST;
            q.vol2 <= VOL_RST;
        end else begin
            q <= d;
        end
    end

    assign ctrl = q.ctrl;
    assign cfg  = q.cfg;
    assign vol1 = q.vol1;
    assign vol2 = q.vol2;

    AST_OVL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ovl_evt |=> q.ovl); // R9
    AST_OCL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ocl_evt |=> q.ocl); // R9
    AST_OVL_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.ovl) |-> $past(reg_wr && !ovl_evt)); // R9
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (q.idx != $past(q.idx)) |->
            ($past(idx_wr) || (q.idx[6:0] == $past(q.idx[6:0]) + 7'd1))); // R6
    AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl & ~CTRL_MASK) == 8'h00); // R8
endmodule

// File: rtl/twowire_regslave.sv
module twowire_regslave #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] ADDR_HI     = 5'b10000,
    parameter logic [7:0] CTRL_MASK   = 8'hC7,
    parameter logic [7:0] CFG_MASK    = 8'h7F,
    parameter logic [7:0] VOL_RST     = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [1:0] addr_sel_i,
    input  logic       ovl_evt_i,
    input  logic       ocl_evt_i,
    input  logic [2:0] stat_live_i,
    input  logic [3:0] fault_live_i,
    input  logic [1:0] spk_miss_i,
    input  logic [7:0] vol_adc_i,
    output logic [7:0] ctrl_o,
    output logic [7:0] cfg_o,
    output logic [7:0] vol1_o,
    output logic [7:0] vol2_o
);
    logic       scl_h, sda_h, scl_rise, scl_fall, start, stop;
    logic       idx_wr, reg_wr, adv;
    logic [7:0] wr_data, rd_data;

    twr_linesync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_o    (scl_h),
        .sda_o    (sda_h),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_o  (start),
        .stop_o   (stop)
    );

    twr_engine #(.ADDR_HI(ADDR_HI)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_h    (scl_h),
        .sda_h    (sda_h),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start    (start),
        .stop     (stop),
        .addr_sel (addr_sel_i),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe_o),
        .idx_wr   (idx_wr),
        .reg_wr   (reg_wr),
        .adv      (adv),
        .wr_data  (wr_data)
    );

    twr_regs #(
        .CTRL_MASK (CTRL_MASK),
        .CFG_MASK  (CFG_MASK),
        .VOL_RST   (VOL_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .reg_wr     (reg_wr),
        .adv        (adv),
        .wr_data    (wr_data),
        .ovl_evt    (ovl_evt_i),
        .ocl_evt    (ocl_evt_i),
        .stat_live  (stat_live_i),
        .fault_live (fault_live_i),
        .spk_miss   (spk_miss_i),
        .vol_adc    (vol_adc_i),
        .rd_data    (rd_data),
        .ctrl       (ctrl_o),
        .cfg        (cfg_o),
        .vol1       (vol1_o),
        .vol2       (vol2_o)
    );
endmodule

// File: tb/twowire_regslave_tb.sv
`timescale 1ns/1ps
module twowire_regslave_tb;
    localparam int Q = 10;
    localparam logic [7:0] AW = 8'h82;
    localparam logic [7:0] AR = 8'h83;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe;
    logic [1:0] addr_sel = 2'b01;
    logic ovl = 1'b0, ocl = 1'b0;
    logic [2:0] stat_live = 3'b000;
    logic [3:0] fault_live = 4'h0;
    logic [1:0] spk_miss = 2'b00;
    logic [7:0] vol_adc = 8'h00;
    logic [7:0] ctrl, cfg, vol1, vol2;
    wire sda_line = sda_m & ~sda_oe;
    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twowire_regslave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .ovl_evt_i(ovl),
        .ocl_evt_i(ocl), .stat_live_i(stat_live), .fault_live_i(fault_live),
        .spk_miss_i(spk_miss), .vol_adc_i(vol_adc), .ctrl_o(ctrl),
        .cfg_o(cfg), .vol1_o(vol1), .vol2_o(vol2)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 1'b0; qw(); sda_m = 1'b1; qw();
        scl_m = 1'b1; qw(); sda_m = 1'b0; qw();
        scl_m = 1'b0; qw();
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; qw();
        scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    endtask

    task automatic recv_bit(output logic v);
        sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); v = sda_line; qw(); scl_m = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic rbyte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(nack);
    endtask

    task automatic write_reg(input logic [7:0] idx, input logic [7:0] val);
        logic a;
        bus_start(); wbyte(AW, a); wbyte(idx, a); wbyte(val, a); bus_stop();
    endtask

    task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
        logic a;
        bus_start(); wbyte(AW, a); wbyte(idx, a);
        bus_start(); wbyte(AR, a); rbyte(1'b1, v); bus_stop();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        logic a;
        chk("R7 ctrl reset", ctrl, 8'h00);
        chk("R7 cfg reset", cfg, 8'h00);
        chk("R7 vol1 reset", vol1, 8'hFF);
        chk("R7 vol2 reset", vol2, 8'hFF);
        chk("R2 line released at reset", {7'd0, sda_oe}, 8'h00);
        stat_live = 3'b010;
        bus_start(); wbyte(AR, a); rbyte(1'b1, v); bus_stop();
        chk("R5 read before index write gives status", v, 8'h02);
        stat_live = 3'b000;
    endtask

    task automatic t_write_autoinc();
        logic a;
        bus_start();
        wbyte(AW, a);   chk("R3 ack on address", {7'd0, a}, 8'h01);
        wbyte(8'h84, a); chk("R3 ack on index byte", {7'd0, a}, 8'h01);
        wbyte(8'hFF, a);
        wbyte(8'hBA, a);
        wbyte(8'h55, a); chk("R3 ack on data byte", {7'd0, a}, 8'h01);
        bus_stop();
        chk("R8 control write mask", ctrl, 8'hC7);
        chk("R8 config write mask", cfg, 8'h3A);
        chk("R6 autoinc reached vol1", vol1, 8'h55);
    endtask

    task automatic t_write_fixed();
        logic a;
        bus_start(); wbyte(AW, a); wbyte(8'h06, a);
        wbyte(8'h11, a); wbyte(8'h22, a); bus_stop();
        chk("R6 fixed index last write wins", vol1, 8'h22);
        chk("R6 fixed index vol2 untouched", vol2, 8'hFF);
    endtask

    task automatic t_read_rs();
        logic a;
        logic [7:0] v;
        bus_start(); wbyte(AW, a); wbyte(8'h84, a);
        bus_start(); wbyte(AR, a); chk("R2 ack after repeated start", {7'd0, a}, 8'h01);
        rbyte(1'b0, v); chk("R4 read byte 1", v, 8'hC7);
        rbyte(1'b0, v); chk("R6 read autoinc byte 2", v, 8'h3A);
        rbyte(1'b1, v); chk("R6 read autoinc byte 3", v, 8'h22);
        qw();
        chk("R4 released after master nack", {7'd0, sda_oe}, 8'h00);
        bus_stop();
    endtask

    task automatic t_wrong_addr();
        logic a;
        bus_start(); wbyte(8'h86, a); chk("R1 no ack for other address", {7'd0, a}, 8'h00);
        wbyte(8'h05, a); chk("R1 ignored after mismatch", {7'd0, a}, 8'h00);
        wbyte(8'h00, a); bus_stop();
        chk("R1 config unchanged", cfg, 8'h3A);
    endtask

    task automatic t_status();
        logic [7:0] v;
        @(negedge clk); ovl = 1'b1; ocl = 1'b1;
        @(negedge clk); ovl = 1'b0; ocl = 1'b0;
        stat_live = 3'b101;
        read_reg(8'h00, v); chk("R9 sticky bits set with R10 live bits", v, 8'hC5);
        write_reg(8'h00, 8'h40);
        read_reg(8'h00, v); chk("R9 write 0 clears, write 1 keeps", v, 8'h45);
        write_reg(8'h00, 8'hFF);
        read_reg(8'h00, v); chk("R9 writing ones has no effect", v, 8'h45);
        @(negedge clk); ovl = 1'b1;
        write_reg(8'h00, 8'h00);
        @(negedge clk); ovl = 1'b0;
        read_reg(8'h00, v); chk("R9 set beats clear", v, 8'h85);
    endtask

    task automatic t_readonly();
        logic a;
        logic [7:0] v;
        fault_live = 4'hA; spk_miss = 2'b01; vol_adc = 8'h5C;
        bus_start(); wbyte(AW, a); wbyte(8'h81, a);
        wbyte(8'hFF, a); wbyte(8'hFF, a); wbyte(8'hFF, a); bus_stop();
        bus_start(); wbyte(AW, a); wbyte(8'h81, a);
        bus_start(); wbyte(AR, a);
        rbyte(1'b0, v); chk("R10 fault live, write ignored", v, 8'h0A);
        rbyte(1'b0, v); chk("R10 initial state live", v, 8'h10);
        rbyte(1'b1, v); chk("R10 volume reading live", v, 8'h5C);
        bus_stop();
        write_reg(8'h09, 8'hFF);
        read_reg(8'h09, v); chk("R8 index 9 reads zero", v, 8'h00);
    endtask

    task automatic t_strap();
        logic a;
        addr_sel = 2'b10;
        repeat (4) @(negedge clk);
        bus_start(); wbyte(8'h84, a); chk("R1 strap 10 address acked", {7'd0, a}, 8'h01);
        bus_stop();
        bus_start(); wbyte(AW, a); chk("R1 old strap address rejected", {7'd0, a}, 8'h00);
        bus_stop();
        addr_sel = 2'b01;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_autoinc();
        t_write_fixed();
        t_read_rs();
        t_wrong_addr();
        t_status();
        t_readonly();
        t_strap();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule